// File: doc/BRIEF.md
# Debug-Arbitrated Bus Router

This block is the bus junction of a small processor subsystem. Two Wishbone masters connect to it: the processor, whose instruction fetches and data accesses already share one master port, and an external debug master. A single debug-mode input decides which of the two owns the fabric. The owner's request is decoded by address and steered either to one shared SRAM port or to a Wishbone peripheral port. The acknowledge and the read data from the chosen target go back to the owner alone.

The intended start-up order is as follows. The system leaves reset with debug mode asserted. The debug master then writes a program into SRAM. When debug mode is cleared, the processor begins fetching from SRAM. While debug mode holds, the processor cannot reach SRAM or any peripheral. The debug master uses the same address decode as the processor, so it reaches SRAM and every peripheral.

Ownership is kept in one register. That register follows the mode input only when the current owner has no open cycle, or on the cycle in which the owner's transfer is acknowledged. A mode change therefore never splits a transfer between the two masters.

Top module: `dbg_bus_router`

## Requirements
- R1: While reset is asserted, and after release until a clock edge samples debug mode low with no open cycle, the debug master is the owner. The encoding is owner 0 = processor, 1 = debug.
- R2: While the debug master owns the bus, processor requests reach neither target, and the processor's acknowledge stays low.
- R3: An owner address of 0x40000000 or above raises cyc and stb on the peripheral port. A lower address raises them on the SRAM port.
- R4: The debug master reaches both SRAM and peripherals through the same decode as the processor.
- R5: The target that is not selected sees cyc and stb held low. At most one target is active at a time.
- R6: The owner's address, write data, byte selects and write enable appear unchanged on the selected target.
- R7: The owner receives the acknowledge and read data of the target its address decodes to. The non-owner sees acknowledge low and read data zero.
- R8: A change of debug mode takes effect on the next clock edge only if the owner has no open cycle, or if its acknowledge is high at that edge. While the owner has an open, unacknowledged cycle, ownership does not change.
- R9: After the debug master writes to SRAM and debug mode is cleared, processor accesses reach SRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_mode_i | input | 1 | High requests ownership for the debug master |
| cpu_adr_i | input | AW | Processor address |
| cpu_dat_i | input | DW | Processor write data |
| cpu_sel_i | input | DW/8 | Processor byte selects |
| cpu_we_i | input | 1 | Processor write enable |
| cpu_cyc_i | input | 1 | Processor cycle |
| cpu_stb_i | input | 1 | Processor strobe |
| cpu_rdt_o | output | DW | Read data to processor |
| cpu_ack_o | output | 1 | Acknowledge to processor |
| dbg_adr_i | input | AW | Debug address |
| dbg_dat_i | input | DW | Debug write data |
| dbg_sel_i | input | DW/8 | Debug byte selects |
| dbg_we_i | input | 1 | Debug write enable |
| dbg_cyc_i | input | 1 | Debug cycle |
| dbg_stb_i | input | 1 | Debug strobe |
| dbg_rdt_o | output | DW | Read data to debug master |
| dbg_ack_o | output | 1 | Acknowledge to debug master |
| ram_adr_o | output | AW | SRAM address |
| ram_dat_o | output | DW | SRAM write data |
| ram_sel_o | output | DW/8 | SRAM byte selects |
| ram_we_o | output | 1 | SRAM write enable |
| ram_cyc_o | output | 1 | SRAM cycle |
| ram_stb_o | output | 1 | SRAM strobe |
| ram_rdt_i | input | DW | SRAM read data |
| ram_ack_i | input | 1 | SRAM acknowledge |
| per_adr_o | output | AW | Peripheral address |
| per_dat_o | output | DW | Peripheral write data |
| per_sel_o | output | DW/8 | Peripheral byte selects |
| per_we_o | output | 1 | Peripheral write enable |
| per_cyc_o | output | 1 | Peripheral cycle |
| per_stb_o | output | 1 | Peripheral strobe |
| per_rdt_i | input | DW | Peripheral read data |
| per_ack_i | input | 1 | Peripheral acknowledge |

## Verification
The decode is swept, for each owner, over every value of the top address nibble and over the edges 0x3FFFFFFF, 0x40000000, 0 and all-ones. In each sweep the non-owner holds an open cycle at a different address. This shows whether the owner's address, and not the other master's, is routed. Each address is tried with only the SRAM acknowledge raised, then with only the peripheral acknowledge raised, and the two read-data values are kept distinct. This separates correct return routing from an acknowledge that leaks from the wrong target. Mode flips are applied once with the bus idle and once during an open cycle that is acknowledged late. These two cases separate deferred hand-over from immediate hand-over.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic {
    OWN_CPU = 1'b0,
    OWN_DBG = 1'b1
  } owner_e;

  // peripheral window: everything at or above the base
  function automatic logic addr_is_periph(input logic [63:0] adr,
                                          input logic [63:0] base);
    return adr >= base;
  endfunction

endpackage

// File: rtl/dbr_owner_latch.sv
module dbr_owner_latch
  import dbr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   dbg_mode_i,
  input  logic   own_cyc_i,
  input  logic   own_ack_i,
  output owner_e owner_o
);

  owner_e owner_q;
  logic   may_switch;

  // hand-over allowed when idle or when the open transfer completes now
  assign may_switch = !own_cyc_i || own_ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n)          owner_q <= OWN_DBG;
    else if (may_switch) owner_q <= dbg_mode_i ? OWN_DBG : OWN_CPU;
  end

  assign owner_o = owner_q;

  // R8
  hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_cyc_i && !own_ack_i) |=> $stable(owner_q));

  // R8
  follow_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_cyc_i && dbg_mode_i) |=> (owner_q == OWN_DBG));

endmodule

// File: rtl/dbr_req_select.sv
module dbr_req_select
  import dbr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int SW = DW / 8
) (
  input  owner_e          owner_i,
  input  logic [AW-1:0]   cpu_adr_i,
  input  logic [DW-1:0]   cpu_dat_i,
  input  logic [SW-1:0]   cpu_sel_i,
  input  logic            cpu_we_i,
  input  logic            cpu_cyc_i,
  input  logic            cpu_stb_i,
  input  logic [AW-1:0]   dbg_adr_i,
  input  logic [DW-1:0]   dbg_dat_i,
  input  logic [SW-1:0]   dbg_sel_i,
  input  logic            dbg_we_i,
  input  logic            dbg_cyc_i,
  input  logic            dbg_stb_i,
  output logic [AW-1:0]   m_adr_o,
  output logic [DW-1:0]   m_dat_o,
  output logic [SW-1:0]   m_sel_o,
  output logic            m_we_o,
  output logic            m_cyc_o,
  output logic            m_stb_o
);

  logic pick_dbg;
  assign pick_dbg = (owner_i == OWN_DBG);

  always_comb begin
    if (pick_dbg) begin
      m_adr_o = dbg_adr_i;
      m_dat_o = dbg_dat_i;
      m_sel_o = dbg_sel_i;
      m_we_o  = dbg_we_i;
      m_cyc_o = dbg_cyc_i;
      m_stb_o = dbg_stb_i;
    end else begin
      m_adr_o = cpu_adr_i;
      m_dat_o = cpu_dat_i;
      m_sel_o = cpu_sel_i;
      m_we_o  = cpu_we_i;
      m_cyc_o = cpu_cyc_i;
      m_stb_o = cpu_stb_i;
    end
  end

endmodule

// File: rtl/dbr_addr_decode.sv
module dbr_addr_decode
  import dbr_pkg::*;
#(
  parameter int          AW          = 32,
  parameter logic [63:0] PERIPH_BASE = 64'h4000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] m_adr_i,
  input  logic          m_cyc_i,
  input  logic          m_stb_i,
  output logic          hit_per_o,
  output logic          ram_cyc_o,
  output logic          ram_stb_o,
  output logic          per_cyc_o,
  output logic          per_stb_o
);

  logic hit_per;
  assign hit_per   = addr_is_periph(64'(m_adr_i), PERIPH_BASE);
  assign hit_per_o = hit_per;

  assign ram_cyc_o = m_cyc_i && !hit_per;
  assign ram_stb_o = m_stb_i && !hit_per;
  assign per_cyc_o = m_cyc_i &&  hit_per;
  assign per_stb_o = m_stb_i &&  hit_per;

  // R5
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_cyc_o, per_cyc_o}));

  // R5
  no_stray_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_cyc_o || per_cyc_o) |-> m_cyc_i);

endmodule

// File: rtl/dbr_resp_return.sv
module dbr_resp_return
  import dbr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  owner_e        owner_i,
  input  logic          m_cyc_i,
  input  logic          m_stb_i,
  input  logic          hit_per_i,
  input  logic [DW-1:0] ram_rdt_i,
  input  logic          ram_ack_i,
  input  logic [DW-1:0] per_rdt_i,
  input  logic          per_ack_i,
  output logic          own_ack_o,
  output logic [DW-1:0] cpu_rdt_o,
  output logic          cpu_ack_o,
  output logic [DW-1:0] dbg_rdt_o,
  output logic          dbg_ack_o
);

  logic          tgt_ack;
  logic [DW-1:0] tgt_rdt;

  assign tgt_ack   = m_cyc_i && m_stb_i && (hit_per_i ? per_ack_i : ram_ack_i);
  assign tgt_rdt   = hit_per_i ? per_rdt_i : ram_rdt_i;
  assign own_ack_o = tgt_ack;

  always_comb begin
    cpu_ack_o = 1'b0;
    dbg_ack_o = 1'b0;
    cpu_rdt_o = '0;
    dbg_rdt_o = '0;
    if (owner_i == OWN_DBG) begin
      dbg_ack_o = tgt_ack;
      dbg_rdt_o = tgt_rdt;
    end else begin
      cpu_ack_o = tgt_ack;
      cpu_rdt_o = tgt_rdt;
    end
  end

  // R7
  single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_ack_o && dbg_ack_o));

  // R7
  ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack_o || dbg_ack_o) |-> (ram_ack_i || per_ack_i));

endmodule

// File: rtl/dbg_bus_router.sv
module dbg_bus_router
  import dbr_pkg::*;
#(
  parameter int          AW          = 32,
  parameter int          DW          = 32,
  parameter logic [63:0] PERIPH_BASE = 64'h4000_0000,
  localparam int         SW          = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_mode_i,
  input  logic [AW-1:0] cpu_adr_i,
  input  logic [DW-1:0] cpu_dat_i,
  input  logic [SW-1:0] cpu_sel_i,
  input  logic          cpu_we_i,
  input  logic          cpu_cyc_i,
  input  logic          cpu_stb_i,
  output logic [DW-1:0] cpu_rdt_o,
  output logic          cpu_ack_o,
  input  logic [AW-1:0] dbg_adr_i,
  input  logic [DW-1:0] dbg_dat_i,
  input  logic [SW-1:0] dbg_sel_i,
  input  logic          dbg_we_i,
  input  logic          dbg_cyc_i,
  input  logic          dbg_stb_i,
  output logic [DW-1:0] dbg_rdt_o,
  output logic          dbg_ack_o,
  output logic [AW-1:0] ram_adr_o,
  output logic [DW-1:0] ram_dat_o,
  output logic [SW-1:0] ram_sel_o,
  output logic          ram_we_o,
  output logic          ram_cyc_o,
  output logic          ram_stb_o,
  input  logic [DW-1:0] ram_rdt_i,
  input  logic          ram_ack_i,
  output logic [AW-1:0] per_adr_o,
  output logic [DW-1:0] per_dat_o,
  output logic [SW-1:0] per_sel_o,
  output logic          per_we_o,
  output logic          per_cyc_o,
  output logic          per_stb_o,
  input  logic [DW-1:0] per_rdt_i,
  input  logic          per_ack_i
);

  owner_e        owner;
  logic [AW-1:0] m_adr;
  logic [DW-1:0] m_dat;
  logic [SW-1:0] m_sel;
  logic          m_we, m_cyc, m_stb;
  logic          hit_per, own_ack;

  dbr_owner_latch u_owner (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbg_mode_i (dbg_mode_i),
    .own_cyc_i  (m_cyc),
    .own_ack_i  (own_ack),
    .owner_o    (owner)
  );

  dbr_req_select #(.AW(AW), .DW(DW)) u_sel (
    .owner_i   (owner),
    .cpu_adr_i (cpu_adr_i), .cpu_dat_i (cpu_dat_i), .cpu_sel_i (cpu_sel_i),
    .cpu_we_i  (cpu_we_i),  .cpu_cyc_i (cpu_cyc_i), .cpu_stb_i (cpu_stb_i),
    .dbg_adr_i (dbg_adr_i), .dbg_dat_i (dbg_dat_i), .dbg_sel_i (dbg_sel_i),
    .dbg_we_i  (dbg_we_i),  .dbg_cyc_i (dbg_cyc_i), .dbg_stb_i (dbg_stb_i),
    .m_adr_o   (m_adr), .m_dat_o (m_dat), .m_sel_o (m_sel),
    .m_we_o    (m_we),  .m_cyc_o (m_cyc), .m_stb_o (m_stb)
  );

  dbr_addr_decode #(.AW(AW), .PERIPH_BASE(PERIPH_BASE)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_adr_i   (m_adr),
    .m_cyc_i   (m_cyc),
    .m_stb_i   (m_stb),
    .hit_per_o (hit_per),
    .ram_cyc_o (ram_cyc_o),
    .ram_stb_o (ram_stb_o),
    .per_cyc_o (per_cyc_o),
    .per_stb_o (per_stb_o)
  );

  dbr_resp_return #(.DW(DW)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .owner_i   (owner),
    .m_cyc_i   (m_cyc),
    .m_stb_i   (m_stb),
    .hit_per_i (hit_per),
    .ram_rdt_i (ram_rdt_i),
    .ram_ack_i (ram_ack_i),
    .per_rdt_i (per_rdt_i),
    .per_ack_i (per_ack_i),
    .own_ack_o (own_ack),
    .cpu_rdt_o (cpu_rdt_o),
    .cpu_ack_o (cpu_ack_o),
    .dbg_rdt_o (dbg_rdt_o),
    .dbg_ack_o (dbg_ack_o)
  );

  // request payload goes to both targets; only cyc/stb select
  assign ram_adr_o = m_adr;
  assign ram_dat_o = m_dat;
  assign ram_sel_o = m_sel;
  assign ram_we_o  = m_we;
  assign per_adr_o = m_adr;
  assign per_dat_o = m_dat;
  assign per_sel_o = m_sel;
  assign per_we_o  = m_we;

  // R2
  cpu_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_DBG && !dbg_cyc_i) |-> (!ram_cyc_o && !per_cyc_o && !cpu_ack_o));

  // R3
  ram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cyc_o |-> (64'(ram_adr_o) < PERIPH_BASE));

  // R3
  per_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_cyc_o |-> (64'(per_adr_o) >= PERIPH_BASE));

endmodule

// File: tb/dbg_bus_router_bench.sv
module dbg_bus_router_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_mode = 1'b1;
  logic [31:0] cpu_adr = '0, cpu_dat = '0, dbg_adr = '0, dbg_dat = '0;
  logic [3:0]  cpu_sel = '0, dbg_sel = '0;
  logic        cpu_we = 1'b0, cpu_cyc = 1'b0, cpu_stb = 1'b0;
  logic        dbg_we = 1'b0, dbg_cyc = 1'b0, dbg_stb = 1'b0;
  logic [31:0] cpu_rdt, dbg_rdt;
  logic        cpu_ack, dbg_ack;
  logic [31:0] ram_adr, ram_dat, per_adr, per_dat;
  logic [3:0]  ram_sel, per_sel;
  logic        ram_we, ram_cyc, ram_stb, per_we, per_cyc, per_stb;
  logic [31:0] ram_rdt = '0, per_rdt = '0;
  logic        ram_ack = 1'b0, per_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dbg_bus_router u_dbg_bus_router (
    .clk(clk), .rst_n(rst_n), .dbg_mode_i(dbg_mode),
    .cpu_adr_i(cpu_adr), .cpu_dat_i(cpu_dat), .cpu_sel_i(cpu_sel),
    .cpu_we_i(cpu_we), .cpu_cyc_i(cpu_cyc), .cpu_stb_i(cpu_stb),
    .cpu_rdt_o(cpu_rdt), .cpu_ack_o(cpu_ack),
    .dbg_adr_i(dbg_adr), .dbg_dat_i(dbg_dat), .dbg_sel_i(dbg_sel),
    .dbg_we_i(dbg_we), .dbg_cyc_i(dbg_cyc), .dbg_stb_i(dbg_stb),
    .dbg_rdt_o(dbg_rdt), .dbg_ack_o(dbg_ack),
    .ram_adr_o(ram_adr), .ram_dat_o(ram_dat), .ram_sel_o(ram_sel),
    .ram_we_o(ram_we), .ram_cyc_o(ram_cyc), .ram_stb_o(ram_stb),
    .ram_rdt_i(ram_rdt), .ram_ack_i(ram_ack),
    .per_adr_o(per_adr), .per_dat_o(per_dat), .per_sel_o(per_sel),
    .per_we_o(per_we), .per_cyc_o(per_cyc), .per_stb_o(per_stb),
    .per_rdt_i(per_rdt), .per_ack_i(per_ack)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sweep_adr(input int i);
    if (i < 16)  return (32'(i) << 28) | (32'(i) * 32'h0011_1110);
    if (i == 16) return 32'h3FFF_FFFF;
    if (i == 17) return 32'h4000_0000;
    if (i == 18) return 32'hFFFF_FFFF;
    return 32'h0000_0000;
  endfunction

  function automatic logic exp_per(input logic [31:0] a);
    return a[31:30] != 2'b00;
  endfunction

  task automatic idle_all();
    cpu_cyc = 0; cpu_stb = 0; dbg_cyc = 0; dbg_stb = 0;
    ram_ack = 0; per_ack = 0;
  endtask

  task automatic set_owner(input logic dbg);
    @(negedge clk);
    idle_all();
    dbg_mode = dbg;
    @(negedge clk);
  endtask

  // one pass over all sweep addresses with the given owner
  task automatic sweep(input logic dbg_owns);
    for (int i = 0; i < 20; i++) begin
      logic [31:0] a, oth, wd;
      logic [3:0]  bs;
      logic        wr, p;
      logic [31:0] o_rdt, n_rdt;
      logic        o_ack, n_ack;
      a   = sweep_adr(i);
      oth = ~a;
      wd  = 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0101);
      bs  = 4'(i + 1);
      wr  = i[0];
      p   = exp_per(a);
      @(negedge clk);
      if (dbg_owns) begin
        dbg_adr = a; dbg_dat = wd; dbg_sel = bs; dbg_we = wr; dbg_cyc = 1; dbg_stb = 1;
        cpu_adr = oth; cpu_dat = ~wd; cpu_sel = ~bs; cpu_we = ~wr; cpu_cyc = 1; cpu_stb = 1;
      end else begin
        cpu_adr = a; cpu_dat = wd; cpu_sel = bs; cpu_we = wr; cpu_cyc = 1; cpu_stb = 1;
        dbg_adr = oth; dbg_dat = ~wd; dbg_sel = ~bs; dbg_we = ~wr; dbg_cyc = 1; dbg_stb = 1;
      end
      ram_rdt = 32'hAAAA_0000 | 32'(i);
      per_rdt = 32'h5555_0000 | 32'(i);
      ram_ack = 0; per_ack = 0;
      #1;
      check(dbg_owns ? "R4 per_cyc" : "R3 per_cyc", 64'(per_cyc), 64'(p));
      check("R5 ram_cyc", 64'(ram_cyc), 64'(!p));
      check("R5 stb pair", 64'({ram_stb, per_stb}), 64'({!p, p}));
      check("R6 adr", 64'(p ? per_adr : ram_adr), 64'(a));
      check("R6 dat", 64'(p ? per_dat : ram_dat), 64'(wd));
      check("R6 sel/we", 64'({p ? per_sel : ram_sel, p ? per_we : ram_we}), 64'({bs, wr}));
      for (int k = 0; k < 2; k++) begin
        ram_ack = (k == 0); per_ack = (k == 1);
        #1;
        o_ack = dbg_owns ? dbg_ack : cpu_ack;
        n_ack = dbg_owns ? cpu_ack : dbg_ack;
        o_rdt = dbg_owns ? dbg_rdt : cpu_rdt;
        n_rdt = dbg_owns ? cpu_rdt : dbg_rdt;
        check("R7 owner ack", 64'(o_ack), 64'((k == 1) == p));
        check("R7 owner rdt", 64'(o_rdt), 64'(p ? per_rdt : ram_rdt));
        check("R7 nonowner ack/rdt", {31'd0, n_ack, n_rdt}, 64'd0);
      end
      idle_all();
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: in reset, debug owns even though the mode pin asks for the processor
    dbg_mode = 0;
    @(negedge clk);
    cpu_cyc = 1; cpu_stb = 1; cpu_adr = 32'h10; ram_ack = 1;
    #1;
    check("R1 reset ram_cyc", 64'(ram_cyc), 0);
    check("R1 reset cpu_ack", 64'(cpu_ack), 0);
    @(negedge clk);
    idle_all();
    rst_n = 1;
    @(negedge clk);
    // edge sampled mode low with no open cycle -> processor owns
    cpu_cyc = 1; cpu_stb = 1; cpu_adr = 32'h20;
    #1;
    check("R1 cpu owner after release", 64'(ram_cyc), 1);
    idle_all();

    // R2: debug owns, processor requests blocked
    set_owner(1);
    cpu_cyc = 1; cpu_stb = 1; cpu_adr = 32'h8000_0000; ram_ack = 1; per_ack = 1;
    #1;
    check("R2 blocked cyc", 64'({ram_cyc, per_cyc}), 0);
    check("R2 blocked ack", 64'(cpu_ack), 0);
    idle_all();

    sweep(1);
    set_owner(0);
    sweep(0);

    // R8: mode change during an open processor cycle is deferred
    @(negedge clk);
    cpu_adr = 32'h0000_0100; cpu_cyc = 1; cpu_stb = 1;
    dbg_adr = 32'h0000_0200; dbg_cyc = 1; dbg_stb = 1;
    dbg_mode = 1;
    repeat (3) @(negedge clk);
    #1;
    check("R8 held owner", 64'(ram_adr), 64'(32'h100));
    ram_ack = 1;
    @(negedge clk);
    ram_ack = 0; cpu_cyc = 0; cpu_stb = 0;
    #1;
    check("R8 switch on ack", 64'(ram_adr), 64'(32'h200));
    // R8: open debug cycle blocks the return to the processor
    dbg_mode = 0;
    repeat (2) @(negedge clk);
    cpu_cyc = 1; cpu_stb = 1;
    #1;
    check("R8 debug held", 64'(ram_adr), 64'(32'h200));
    dbg_cyc = 0; dbg_stb = 0; cpu_cyc = 0; cpu_stb = 0;

    // R9: load through debug, then processor fetches from SRAM
    set_owner(1);
    dbg_adr = 32'h0; dbg_dat = 32'h0000_0013; dbg_we = 1; dbg_sel = 4'hF;
    dbg_cyc = 1; dbg_stb = 1; ram_ack = 1;
    #1;
    check("R9 load write", 64'({ram_cyc, ram_we, dbg_ack}), 64'(3'b111));
    set_owner(0);
    cpu_adr = 32'h0; cpu_we = 0; cpu_cyc = 1; cpu_stb = 1;
    ram_rdt = 32'h0000_0013; ram_ack = 1;
    #1;
    check("R9 fetch", 64'({cpu_ack, cpu_rdt}), {31'd0, 1'b1, 32'h13});
    idle_all();

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule